// File: doc/BRIEF.md
# Packed-Result Sequential Integer Divider

This block divides an integer dividend by a divisor over several clock cycles and returns quotient and remainder packed into one destination word. It has two sizes. The narrow form takes a 16-bit dividend and an 8-bit divisor and yields an 8-bit quotient and an 8-bit remainder. The wide form takes a 32-bit dividend and a 16-bit divisor and yields a 16-bit quotient and a 16-bit remainder. In both forms the quotient occupies the lower half of the packed word and the remainder the upper half. Each division can be unsigned or two's-complement signed. Signed division truncates toward zero, and the remainder carries the sign of the dividend.

A request is a one-cycle `start_i` with operands, `wide_i` and `signed_i`. The controller has three states. In `ST_IDLE` it waits for a request. In `ST_ITER` it runs one restoring shift-subtract step per clock on operand magnitudes. In `ST_FIX` it applies sign correction, packs the result and updates the flags.

The transitions are as follows:
- Start with a non-zero divisor: `ST_IDLE`→`ST_ITER`.
- Start with a zero divisor: `ST_IDLE`→`ST_IDLE`, with a divide-by-zero completion.
- More quotient bits to produce: `ST_ITER`→`ST_ITER`.
- Last quotient bit produced: `ST_ITER`→`ST_FIX`.
- Correction done: `ST_FIX`→`ST_IDLE`.

Results are defined only when the quotient magnitude fits the quotient field. Overflow beyond that is not detected.

Top module: `pkdiv_unit`

## Requirements
- R1: With `wide_i`=0, the divisor is `divisor_i[7:0]` and the dividend is `dividend_i[15:0]` (bits 31:16 have no effect). The result carries the quotient in bits 7:0, the remainder in bits 15:8, and zero in bits 31:16.
- R2: With `wide_i`=1, the result carries the 16-bit quotient in bits 15:0 and the 16-bit remainder in bits 31:16.
- R3: With `signed_i`=0, both operands are unsigned binary values.
- R4: With `signed_i`=1 and `wide_i`=0, the 16-bit dividend and the 8-bit divisor are two's complement. The quotient truncates toward zero and the remainder has the sign of the dividend.
- R5: With `signed_i`=1 and `wide_i`=1, the 32-bit dividend and the 16-bit divisor are two's complement, with the same truncation and remainder sign.
- R6: On completion, `flag_n_o` equals the most significant bit of the quotient field (bit 7 narrow, bit 15 wide), and `flag_z_o` is 1 exactly when the quotient field is zero.
- R7: A zero divisor (of the selected size) raises `done_o` and `div_zero_o` together in the cycle right after the start edge, and leaves `result_o`, `flag_n_o` and `flag_z_o` unchanged.
- R8: For a non-zero divisor, `done_o` is high for exactly one cycle, which begins Q+1 clock edges after the edge that sampled `start_i` (Q = 8 narrow, 16 wide). `div_zero_o` stays 0 in that cycle.
- R9: `start_i` has no effect while a division is in `ST_ITER` or `ST_FIX`. A request presented in the cycle where `done_o` is high is accepted.
- R10: After reset, `done_o`, `div_zero_o`, `flag_n_o`, `flag_z_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (taken in ST_IDLE only) |
| dividend_i | input | 32 | Dividend (low 16 bits used in the narrow form) |
| divisor_i | input | 16 | Divisor (low 8 bits used in the narrow form) |
| wide_i | input | 1 | 1 = 32/16 form, 0 = 16/8 form |
| signed_i | input | 1 | 1 = two's-complement operands |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed remainder (upper half) and quotient (lower half) |
| flag_n_o | output | 1 | Sign bit of the quotient field |
| flag_z_o | output | 1 | Quotient field is zero |
| div_zero_o | output | 1 | Completion was a divide by zero |

## Verification
Two functions can meet in the same cycle. The first is completion: the `done_o` pulse and the result update. The second is request acceptance, since the controller is already back in `ST_IDLE` during the done cycle. The bench provokes this by raising `start_i` in the very cycle it observes `done_o` high. It checks that the first result is intact in that cycle and that the second request completes with its own correct latency and value. It also raises `start_i` during iteration and during the correction cycle, and checks that neither disturbs the running result or creates an extra completion.

// File: rtl/pkdiv_pkg.sv
package pkdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } pkdiv_state_e;
endpackage

// File: rtl/pkdiv_prep.sv
// Converts raw operands into unsigned magnitudes aligned for the shared
// shift-subtract datapath, and records which signs must be restored.
module pkdiv_prep #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] dvd_i,
    input  logic [HALF_W-1:0]   dvs_i,
    input  logic                wide_i,
    input  logic                sgn_i,
    output logic [HALF_W-1:0]   rem_init_o,
    output logic [HALF_W-1:0]   quo_init_o,
    output logic [HALF_W-1:0]   dvs_mag_o,
    output logic                neg_q_o,
    output logic                neg_r_o,
    output logic                dvs_zero_o
);
    localparam int FULL_W   = 2 * HALF_W;
    localparam int NARROW_W = HALF_W / 2;

    logic                dvd_neg;
    logic                dvs_neg;
    logic [FULL_W-1:0]   mag_full;
    logic [HALF_W-1:0]   mag_half;
    logic [NARROW_W-1:0] mag_dvs_n;

    always_comb begin
        dvd_neg   = sgn_i & (wide_i ? dvd_i[FULL_W-1] : dvd_i[HALF_W-1]);
        dvs_neg   = sgn_i & (wide_i ? dvs_i[HALF_W-1] : dvs_i[NARROW_W-1]);
        mag_full  = dvd_neg ? -dvd_i : dvd_i;
        mag_half  = dvd_neg ? -dvd_i[HALF_W-1:0] : dvd_i[HALF_W-1:0];
        mag_dvs_n = dvs_neg ? -dvs_i[NARROW_W-1:0] : dvs_i[NARROW_W-1:0];
        if (wide_i) begin
            rem_init_o = mag_full[FULL_W-1:HALF_W];
            quo_init_o = mag_full[HALF_W-1:0];
            dvs_mag_o  = dvs_neg ? -dvs_i : dvs_i;
            dvs_zero_o = (dvs_i == '0);
        end else begin
            // narrow dividend bits sit at the top of the quotient shifter
            rem_init_o = {{NARROW_W{1'b0}}, mag_half[HALF_W-1:NARROW_W]};
            quo_init_o = {mag_half[NARROW_W-1:0], {NARROW_W{1'b0}}};
            dvs_mag_o  = {{NARROW_W{1'b0}}, mag_dvs_n};
            dvs_zero_o = (dvs_i[NARROW_W-1:0] == '0);
        end
        neg_r_o = dvd_neg;
        neg_q_o = dvd_neg ^ dvs_neg;
    end
endmodule

// File: rtl/pkdiv_step.sv
// One restoring step: shift one dividend bit into the partial remainder,
// subtract the divisor when it fits, emit one quotient bit.
module pkdiv_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic         shin_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic         qbit_o
);
    logic [W:0]   trial;
    logic [W-1:0] diff;

    always_comb begin
        trial  = {rem_i, shin_i};
        qbit_o = (trial >= {1'b0, dvs_i});
        diff   = trial[W-1:0] - dvs_i;
        rem_o  = qbit_o ? diff : trial[W-1:0];
    end
endmodule

// File: rtl/pkdiv_pack.sv
// Restores signs on quotient/remainder magnitudes and packs them.
module pkdiv_pack #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   quo_i,
    input  logic [HALF_W-1:0]   rem_i,
    input  logic                wide_i,
    input  logic                neg_q_i,
    input  logic                neg_r_i,
    output logic [2*HALF_W-1:0] packed_o,
    output logic                n_o,
    output logic                z_o
);
    localparam int NARROW_W = HALF_W / 2;

    logic [HALF_W-1:0]   qw, rw;
    logic [NARROW_W-1:0] qn, rn;

    always_comb begin
        qw = neg_q_i ? -quo_i : quo_i;
        rw = neg_r_i ? -rem_i : rem_i;
        qn = neg_q_i ? -quo_i[NARROW_W-1:0] : quo_i[NARROW_W-1:0];
        rn = neg_r_i ? -rem_i[NARROW_W-1:0] : rem_i[NARROW_W-1:0];
        if (wide_i) begin
            packed_o = {rw, qw};
            n_o      = qw[HALF_W-1];
            z_o      = (qw == '0);
        end else begin
            packed_o = {{HALF_W{1'b0}}, rn, qn};
            n_o      = qn[NARROW_W-1];
            z_o      = (qn == '0);
        end
    end
endmodule

// File: rtl/pkdiv_unit.sv
module pkdiv_unit
    import pkdiv_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*HALF_W-1:0] dividend_i,
    input  logic [HALF_W-1:0]   divisor_i,
    input  logic                wide_i,
    input  logic                signed_i,
    output logic                done_o,
    output logic [2*HALF_W-1:0] result_o,
    output logic                flag_n_o,
    output logic                flag_z_o,
    output logic                div_zero_o
);
    localparam int FULL_W   = 2 * HALF_W;
    localparam int NARROW_W = HALF_W / 2;
    localparam int CNT_W    = $clog2(HALF_W);
    localparam logic [CNT_W-1:0] CNT_WIDE   = CNT_W'(HALF_W - 1);
    localparam logic [CNT_W-1:0] CNT_NARROW = CNT_W'(NARROW_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    pkdiv_state_e state_q, state_d;

    logic [HALF_W-1:0] rem_q, quo_q, dvs_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wide_q, negq_q, negr_q;

    logic [HALF_W-1:0] rem_init, quo_init, dvs_mag;
    logic              neg_q, neg_r, dvs_zero;
    logic [HALF_W-1:0] rem_nxt;
    logic              qbit;
    logic [FULL_W-1:0] packed_res;
    logic              pk_n, pk_z;

    pkdiv_prep #(.HALF_W(HALF_W)) u_prep (
        .dvd_i      (dividend_i),
        .dvs_i      (divisor_i),
        .wide_i     (wide_i),
        .sgn_i      (signed_i),
        .rem_init_o (rem_init),
        .quo_init_o (quo_init),
        .dvs_mag_o  (dvs_mag),
        .neg_q_o    (neg_q),
        .neg_r_o    (neg_r),
        .dvs_zero_o (dvs_zero)
    );

    pkdiv_step #(.W(HALF_W)) u_step (
        .rem_i  (rem_q),
        .shin_i (quo_q[HALF_W-1]),
        .dvs_i  (dvs_q),
        .rem_o  (rem_nxt),
        .qbit_o (qbit)
    );

    pkdiv_pack #(.HALF_W(HALF_W)) u_pack (
        .quo_i    (quo_q),
        .rem_i    (rem_q),
        .wide_i   (wide_q),
        .neg_q_i  (negq_q),
        .neg_r_i  (negr_q),
        .packed_o (packed_res),
        .n_o      (pk_n),
        .z_o      (pk_z)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i && !dvs_zero) state_d = ST_ITER;
            ST_ITER: if (cnt_q == '0)          state_d = ST_FIX;
            ST_FIX:                            state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q      <= '0;
            quo_q      <= '0;
            dvs_q      <= '0;
            cnt_q      <= '0;
            wide_q     <= 1'b0;
            negq_q     <= 1'b0;
            negr_q     <= 1'b0;
            done_o     <= 1'b0;
            div_zero_o <= 1'b0;
            result_o   <= '0;
            flag_n_o   <= 1'b0;
            flag_z_o   <= 1'b0;
        end else begin
            done_o     <= 1'b0;
            div_zero_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (dvs_zero) begin
                            done_o     <= 1'b1;
                            div_zero_o <= 1'b1;
                        end else begin
                            rem_q  <= rem_init;
                            quo_q  <= quo_init;
                            dvs_q  <= dvs_mag;
                            cnt_q  <= wide_i ? CNT_WIDE : CNT_NARROW;
                            wide_q <= wide_i;
                            negq_q <= neg_q;
                            negr_q <= neg_r;
                        end
                    end
                end
                ST_ITER: begin
                    rem_q <= rem_nxt;
                    quo_q <= {quo_q[HALF_W-2:0], qbit};
                    cnt_q <= cnt_q - CNT_ONE;
                end
                ST_FIX: begin
                    result_o <= packed_res;
                    flag_n_o <= pk_n;
                    flag_z_o <= pk_z;
                    done_o   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_ITER_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> !done_o); // R8
    AST_FIX_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |=> (done_o && !div_zero_o)); // R8
    AST_DZ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> done_o); // R7
    AST_DZ_HOLDS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (result_o == $past(result_o) && flag_n_o == $past(flag_n_o)
                        && flag_z_o == $past(flag_z_o))); // R7
    AST_BUSY_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |=> (state_q != ST_IDLE)); // R9
endmodule

// File: tb/pkdiv_unit_tb.sv
module pkdiv_unit_tb;
    localparam int HW       = 16;
    localparam int LAT_NARR = 9;
    localparam int LAT_WIDE = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic        wide_i = 1'b0;
    logic        signed_i = 1'b0;
    logic        done_o, flag_n_o, flag_z_o, div_zero_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;

    // model of destination state
    logic [31:0] m_res = '0;
    logic        m_n = 1'b0, m_z = 1'b0;

    always #5 clk = ~clk;

    pkdiv_unit #(.HALF_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
        .divisor_i(divisor_i), .wide_i(wide_i), .signed_i(signed_i),
        .done_o(done_o), .result_o(result_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .div_zero_o(div_zero_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compute expected packed result and flags from the requirements
    task automatic model(input logic [31:0] dvd, input logic [15:0] dvs,
                         input bit wide, input bit sgn);
        longint a, b, q, r;
        if (wide) begin
            a = sgn ? longint'($signed(dvd)) : longint'(dvd);
            b = sgn ? longint'($signed(dvs)) : longint'(dvs);
        end else begin
            a = sgn ? longint'($signed(dvd[15:0])) : longint'(dvd[15:0]);
            b = sgn ? longint'($signed(dvs[7:0])) : longint'(dvs[7:0]);
        end
        q = a / b;
        r = a % b;
        if (wide) begin
            m_res = {r[15:0], q[15:0]};
            m_n   = q[15];
            m_z   = (q[15:0] == 16'h0);
        end else begin
            m_res = {16'h0, r[7:0], q[7:0]};
            m_n   = q[7];
            m_z   = (q[7:0] == 8'h0);
        end
    endtask

    task automatic drive(input logic [31:0] dvd, input logic [15:0] dvs,
                         input bit wide, input bit sgn);
        dividend_i = dvd; divisor_i = dvs; wide_i = wide; signed_i = sgn;
        start_i = 1'b1;
    endtask

    // wait from just after the sampling edge until done; returns latency
    task automatic wait_done(output int lat);
        lat = 0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_div(input logic [31:0] dvd, input logic [15:0] dvs,
                           input bit wide, input bit sgn, input string req);
        int lat;
        bit dz;
        dz = wide ? (dvs == 16'h0) : (dvs[7:0] == 8'h0);
        if (!dz) model(dvd, dvs, wide, sgn);
        @(negedge clk);
        drive(dvd, dvs, wide, sgn);
        @(posedge clk);
        wait_done(lat);
        if (dz) begin
            chk(lat == 0, "R7", "dz latency", lat, 0);
            chk(div_zero_o == 1'b1, "R7", "div_zero", div_zero_o, 1);
        end else begin
            chk(lat == (wide ? LAT_WIDE : LAT_NARR), "R8", "latency", lat,
                wide ? LAT_WIDE : LAT_NARR);
            chk(div_zero_o == 1'b0, "R8", "div_zero low", div_zero_o, 0);
        end
        chk(result_o == m_res, req, "result", result_o, m_res);
        chk(flag_n_o == m_n, "R6", "flag N", flag_n_o, m_n);
        chk(flag_z_o == m_z, "R6", "flag Z", flag_z_o, m_z);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done single pulse", done_o, 0);
    endtask

    task automatic t_reset;
        chk(done_o == 0 && div_zero_o == 0, "R10", "reset done/dz",
            {done_o, div_zero_o}, 0);
        chk(result_o == 0, "R10", "reset result", result_o, 0);
        chk(flag_n_o == 0 && flag_z_o == 0, "R10", "reset flags",
            {flag_n_o, flag_z_o}, 0);
    endtask

    task automatic t_narrow_unsigned;
        run_div(32'h0000_03E8, 16'h0007, 1'b0, 1'b0, "R3");   // 1000/7
        run_div(32'hABCD_03E8, 16'hFF07, 1'b0, 1'b0, "R1");   // upper bits ignored
        run_div(32'h0000_0005, 16'h0009, 1'b0, 1'b0, "R1");   // zero quotient
    endtask

    task automatic t_narrow_signed;
        run_div(32'h0000_FED4, 16'h0007, 1'b0, 1'b1, "R4");   // -300/7
        run_div(32'h0000_012C, 16'h00F9, 1'b0, 1'b1, "R4");   // 300/-7
        run_div(32'h0000_FED4, 16'h00F9, 1'b0, 1'b1, "R4");   // -300/-7
    endtask

    task automatic t_wide;
        run_div(32'd1000000, 16'd300, 1'b1, 1'b0, "R2");
        run_div(32'hFFFE_0001, 16'hFFFF, 1'b1, 1'b0, "R3");
        run_div(32'h0001_0000, 16'h0100, 1'b1, 1'b0, "R2");
        run_div(-32'sd1000000, 16'd300, 1'b1, 1'b1, "R5");
        run_div(32'd1000000, -16'sd300, 1'b1, 1'b1, "R5");
    endtask

    task automatic t_zero_divisor;
        run_div(32'h0000_1234, 16'hAB00, 1'b0, 1'b0, "R7");   // narrow zero
        run_div(32'h0000_1234, 16'h0000, 1'b1, 1'b1, "R7");   // wide zero
    endtask

    task automatic t_busy;
        int lat;
        model(32'd1000000, 16'd300, 1'b1, 1'b0);
        @(negedge clk);
        drive(32'd1000000, 16'd300, 1'b1, 1'b0);
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat == 5 || lat == 16) drive(32'h0000_0064, 16'h0003, 1'b0, 1'b0);
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(lat == LAT_WIDE, "R9", "latency with stray starts", lat, LAT_WIDE);
        chk(result_o == m_res, "R9", "result with stray starts", result_o, m_res);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (done_o) chk(1'b0, "R9", "extra done", done_o, 0);
        end
        chk(result_o == m_res, "R9", "result unchanged after", result_o, m_res);
    endtask

    task automatic t_back_to_back;
        int lat;
        logic [31:0] first;
        model(32'h0000_03E8, 16'h0007, 1'b0, 1'b0);
        first = m_res;
        @(negedge clk);
        drive(32'h0000_03E8, 16'h0007, 1'b0, 1'b0);
        @(posedge clk);
        wait_done(lat);
        chk(result_o == first, "R9", "first result in done cycle", result_o, first);
        drive(32'd1000000, 16'd300, 1'b1, 1'b0);   // in the done cycle
        model(32'd1000000, 16'd300, 1'b1, 1'b0);
        @(posedge clk);
        wait_done(lat);
        chk(lat == LAT_WIDE, "R9", "second latency", lat, LAT_WIDE);
        chk(result_o == m_res, "R9", "second result", result_o, m_res);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow_unsigned();
        t_narrow_signed();
        t_wide();
        t_zero_divisor();
        t_busy();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule